// File: doc/BRIEF.md
# Inter-processor interrupt mailbox

A register-mapped controller that lets any core in a small multi-core cluster interrupt another core and hand it a 16-bit message. Each core owns two 32-bit words. The first is a write-only control word. The core writes it to send a message to a named destination core, or to acknowledge its own pending interrupt. The second is a read-only status word. It shows whether a message is waiting and, if so, which core sent it and what the payload is. Each core has its own interrupt output. That output is a level signal and stays high until the core acknowledges the message.

The register file has `NUM_PORTS` independent bus ports, by default one per core, so several cores can send in the same clock cycle. The address on each port is a word address. Bit 0 picks control (0) or status (1), and the upper bits give the core index. In byte terms, core c's control word sits at byte offset 8c and its status word at 8c+4. The controller only moves whole 32-bit words. A big-endian bus bridge upstream places them in memory most significant byte first, so a two-core instance fills 16 bytes. The controller has no interrupt inputs: only register writes trigger it.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset every interrupt output is low and every status word reads as zero.
- R2: Core c's control word is at word address 2c and its status word at 2c+1. Reading a control word returns zero. Status bit 31 always reads zero. A read returns data on `rdata_o` of the same port in the cycle after the request.
- R3: A write to core c's control word with bit 30 set sends a message. Bits 29..16 hold the destination d and bits 15..0 the payload. In the next cycle, d's status word reads bit 30 = 1, bits 29..16 = c and bits 15..0 = the payload.
- R4: `irq_o[d]` is high exactly while d has a message pending. It does not change in any cycle that follows a cycle without writes.
- R5: A write to core c's control word with bit 31 set clears c's pending flag and `irq_o[c]` in the next cycle. The stored source and payload are kept.
- R6: A send that names a destination index at or above `NUM_CORES` changes no state.
- R7: When several control words send to the same destination in one cycle, the message from the lowest core index is stored and the others are dropped.
- R8: A send to a destination that is already pending overwrites its source and payload, and the pending flag stays set.
- R9: If an acknowledge for core d and a send to d land in the same cycle, the send wins: d stays pending with the new source and payload. This also holds when both bits come in one word that a core writes to itself.
- R10: Writes to status words, and writes to core indices at or above `NUM_CORES`, have no effect. Reads of core indices at or above `NUM_CORES` return zero.
- R11: When two ports write the same control word in one cycle, the lower-numbered port's write is taken and the other is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_PORTS | Access strobe, one per port |
| we_i | input | NUM_PORTS | Write (1) or read (0), one per port |
| addr_i | input | NUM_PORTS*(IDX_W+1) | Word address per port: bit 0 status/control, upper bits core index |
| wdata_i | input | NUM_PORTS*32 | Write data per port |
| rdata_o | output | NUM_PORTS*32 | Registered read data per port |
| irq_o | output | NUM_CORES | Level interrupt per core |

## Verification
The bench first sends single messages and checks the interrupt line, the status fields and the reads of control words. This separates correct latching from decode errors on the source field and the payload field. It then sends a second message to a destination that is already pending, and sends to out-of-range destinations. These separate an overwrite from a dropped message, and a rejected index from one that aliases onto a real core. Last come same-cycle collisions: two senders to one destination, two ports writing one control word, and an acknowledge racing a send. These expose the wrong winner in arbitration and the wrong priority between set and clear. Stray writes to status words and to unmapped addresses must leave both the interrupts and the status reads unchanged.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W = 32;
  localparam int CORE_FIELD_W = 14;
  localparam int MSG_W = 16;

  typedef struct packed {
    logic                    ack;
    logic                    gen;
    logic [CORE_FIELD_W-1:0] dst;
    logic [MSG_W-1:0]        msg;
  } ctrl_word_t;

  typedef struct packed {
    logic                    rsvd;
    logic                    pend;
    logic [CORE_FIELD_W-1:0] src;
    logic [MSG_W-1:0]        msg;
  } stat_word_t;
endpackage

// File: rtl/ipi_port_decode.sv
module ipi_port_decode #(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 2,
  localparam int AW       = IDX_W + 1
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  output logic [IDX_W-1:0] core_o,
  output logic             wr_ctrl_o,
  output logic             rd_stat_o
);
  logic hit;
  logic is_stat;

  assign core_o    = addr_i[AW-1:1];
  assign is_stat   = addr_i[0];
  assign hit       = 32'(core_o) < 32'(NUM_CORES);
  assign wr_ctrl_o = req_i & we_i & hit & ~is_stat;
  assign rd_stat_o = req_i & ~we_i & hit & is_stat;
endmodule

// File: rtl/ipi_ctrl_sel.sv
module ipi_ctrl_sel
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_PORTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic       [NUM_PORTS-1:0]            wr_i,
  input  logic       [NUM_PORTS-1:0][IDX_W-1:0] core_i,
  input  ctrl_word_t [NUM_PORTS-1:0]            word_i,
  output logic       [NUM_CORES-1:0]            vld_o,
  output ctrl_word_t [NUM_CORES-1:0]            word_o
);
  // lowest port wins: scan high to low so the last match is the lowest
  always_comb begin
    vld_o  = '0;
    word_o = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
        if (wr_i[p] && core_i[p] == IDX_W'(c)) begin
          vld_o[c]  = 1'b1;
          word_o[c] = word_i[p];
        end
      end
    end
  end
endmodule

// File: rtl/ipi_dest_arb.sv
module ipi_dest_arb
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 2
) (
  input  logic       [NUM_CORES-1:0]            vld_i,
  input  ctrl_word_t [NUM_CORES-1:0]            word_i,
  output logic       [NUM_CORES-1:0]            load_o,
  output logic       [NUM_CORES-1:0][IDX_W-1:0] src_o,
  output logic       [NUM_CORES-1:0][MSG_W-1:0] msg_o,
  output logic       [NUM_CORES-1:0]            ack_o
);
  always_comb begin
    load_o = '0;
    src_o  = '0;
    msg_o  = '0;
    for (int d = 0; d < NUM_CORES; d++) begin
      for (int c = NUM_CORES - 1; c >= 0; c--) begin
        // out-of-range destinations never match any d
        if (vld_i[c] && word_i[c].gen && word_i[c].dst == CORE_FIELD_W'(d)) begin
          load_o[d] = 1'b1;
          src_o[d]  = IDX_W'(c);
          msg_o[d]  = word_i[c].msg;
        end
      end
    end
    for (int c = 0; c < NUM_CORES; c++) ack_o[c] = vld_i[c] & word_i[c].ack;
  end
endmodule

// File: rtl/ipi_mbox_slot.sv
module ipi_mbox_slot
  import ipi_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] src_i,
  input  logic [MSG_W-1:0] msg_i,
  output logic             pend_o,
  output logic [IDX_W-1:0] src_o,
  output logic [MSG_W-1:0] msg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      src_o  <= '0;
      msg_o  <= '0;
    end else if (load_i) begin
      // a new message beats a same-cycle acknowledge
      pend_o <= 1'b1;
      src_o  <= src_i;
      msg_o  <= msg_i;
    end else if (ack_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_PORTS = NUM_CORES,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int AW       = IDX_W + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        req_i,
  input  logic [NUM_PORTS-1:0]        we_i,
  input  logic [NUM_PORTS*AW-1:0]     addr_i,
  input  logic [NUM_PORTS*WORD_W-1:0] wdata_i,
  output logic [NUM_PORTS*WORD_W-1:0] rdata_o,
  output logic [NUM_CORES-1:0]        irq_o
);
  logic       [NUM_PORTS-1:0][IDX_W-1:0] port_core;
  logic       [NUM_PORTS-1:0]            port_wr;
  logic       [NUM_PORTS-1:0]            port_rd;
  ctrl_word_t [NUM_PORTS-1:0]            port_word;

  ctrl_word_t [NUM_CORES-1:0]            ctl_word;
  logic       [NUM_CORES-1:0]            ctl_vld;
  logic       [NUM_CORES-1:0]            slot_load;
  logic       [NUM_CORES-1:0]            slot_ack;
  logic       [NUM_CORES-1:0][IDX_W-1:0] slot_src_in;
  logic       [NUM_CORES-1:0][MSG_W-1:0] slot_msg_in;
  logic       [NUM_CORES-1:0]            slot_pend;
  logic       [NUM_CORES-1:0][IDX_W-1:0] slot_src;
  logic       [NUM_CORES-1:0][MSG_W-1:0] slot_msg;
  stat_word_t [NUM_CORES-1:0]            stat_w;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ipi_port_decode #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_dec (
      .req_i     (req_i[p]),
      .we_i      (we_i[p]),
      .addr_i    (addr_i[p*AW +: AW]),
      .core_o    (port_core[p]),
      .wr_ctrl_o (port_wr[p]),
      .rd_stat_o (port_rd[p])
    );
    assign port_word[p] = ctrl_word_t'(wdata_i[p*WORD_W +: WORD_W]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdata_o[p*WORD_W +: WORD_W] <= '0;
      else         rdata_o[p*WORD_W +: WORD_W] <= port_rd[p] ? stat_w[port_core[p]] : '0;
    end
  end

  ipi_ctrl_sel #(.NUM_CORES(NUM_CORES), .NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_sel (
    .wr_i   (port_wr),
    .core_i (port_core),
    .word_i (port_word),
    .vld_o  (ctl_vld),
    .word_o (ctl_word)
  );

  ipi_dest_arb #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_arb (
    .vld_i  (ctl_vld),
    .word_i (ctl_word),
    .load_o (slot_load),
    .src_o  (slot_src_in),
    .msg_o  (slot_msg_in),
    .ack_o  (slot_ack)
  );

  for (genvar d = 0; d < NUM_CORES; d++) begin : g_slot
    ipi_mbox_slot #(.IDX_W(IDX_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (slot_load[d]),
      .ack_i  (slot_ack[d]),
      .src_i  (slot_src_in[d]),
      .msg_i  (slot_msg_in[d]),
      .pend_o (slot_pend[d]),
      .src_o  (slot_src[d]),
      .msg_o  (slot_msg[d])
    );
    assign stat_w[d] = '{rsvd: 1'b0, pend: slot_pend[d],
                         src: CORE_FIELD_W'(slot_src[d]), msg: slot_msg[d]};
  end

  assign irq_o = slot_pend;
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
  parameter int NUM_CORES = 4,
  parameter int NUM_PORTS = NUM_CORES
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_PORTS-1:0]    req_i,
  input logic [NUM_PORTS-1:0]    we_i,
  input logic [NUM_PORTS*32-1:0] wdata_i,
  input logic [NUM_PORTS*32-1:0] rdata_o,
  input logic [NUM_CORES-1:0]    irq_o
);
  logic any_wr, any_gen, any_ack;

  always_comb begin
    any_wr  = 1'b0;
    any_gen = 1'b0;
    any_ack = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (req_i[p] && we_i[p]) begin
        any_wr  = 1'b1;
        any_gen = any_gen | wdata_i[p*32+30];
        any_ack = any_ack | wdata_i[p*32+31];
      end
    end
  end

  // R4
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_wr |=> $stable(irq_o));

  for (genvar d = 0; d < NUM_CORES; d++) begin : g_dst
    // R3
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[d]) |-> $past(any_gen));
    // R5
    irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o[d]) |-> $past(any_ack));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    // R2
    rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o[p*32+31] == 1'b0);
  end
endmodule

bind ipi_mailbox ipi_mailbox_chk #(.NUM_CORES(NUM_CORES), .NUM_PORTS(NUM_PORTS)) u_chk (.*);

// File: tb/ipi_mailbox_bench.sv
module ipi_mailbox_bench;
  localparam int N  = 3;
  localparam int P  = 3;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int AW = IW + 1;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [P-1:0]    req = '0;
  logic [P-1:0]    we = '0;
  logic [P*AW-1:0] addr = '0;
  logic [P*32-1:0] wdata = '0;
  logic [P*32-1:0] rdata;
  logic [N-1:0]    irq;

  int errors = 0;
  int checks = 0;

  int          q_port[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  logic        rd_live = 1'b0;

  always #5 clk = ~clk;

  ipi_mailbox #(.NUM_CORES(N), .NUM_PORTS(P)) u_ipi_mailbox (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] ctl(bit a, bit g, int dst, logic [15:0] m);
    return {a, g, 14'(dst), m};
  endfunction

  function automatic logic [31:0] st(bit pend, int src, logic [15:0] m);
    return {1'b0, pend, 14'(src), m};
  endfunction

  function automatic int ca(int c); return 2 * c; endfunction
  function automatic int sa(int c); return 2 * c + 1; endfunction

  task automatic put(int p, bit w, int a, logic [31:0] d);
    req[p] = 1'b1;
    we[p]  = w;
    addr[p*AW +: AW]  = AW'(a);
    wdata[p*32 +: 32] = d;
  endtask

  task automatic step();
    @(negedge clk);
    req = '0;
    we  = '0;
  endtask

  task automatic wr(int p, int a, logic [31:0] d);
    put(p, 1'b1, a, d);
    step();
  endtask

  task automatic rd(int p, int a, logic [31:0] exp, string tag);
    q_port.push_back(p);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    put(p, 1'b0, a, '0);
    step();
  endtask

  task automatic chk_irq(logic [N-1:0] exp, string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, exp);
    end
  endtask

  // monitor: scoreboard pops one expected read per returned read
  always @(posedge clk) rd_live <= |(req & ~we);

  always @(negedge clk) begin
    if (rd_live && q_port.size() > 0) begin
      automatic int          p   = q_port.pop_front();
      automatic logic [31:0] e   = q_exp.pop_front();
      automatic string       tag = q_tag.pop_front();
      checks++;
      if (rdata[p*32 +: 32] !== e) begin
        errors++;
        $display("FAIL %s rdata: got %h expected %h", tag, rdata[p*32 +: 32], e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_irq('0, "R1");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_irq('0, "R1");
    for (int c = 0; c < N; c++) rd(0, sa(c), '0, "R1");

    // single send core0 -> core2
    wr(0, ca(0), ctl(0, 1, 2, 16'hBEEF));
    chk_irq(3'b100, "R3");
    rd(1, sa(2), st(1, 0, 16'hBEEF), "R3");
    rd(0, ca(0), '0, "R2");
    rd(2, sa(0), '0, "R2");
    repeat (3) @(negedge clk);
    chk_irq(3'b100, "R4");

    // overwrite while pending
    wr(1, ca(1), ctl(0, 1, 2, 16'h1234));
    chk_irq(3'b100, "R8");
    rd(0, sa(2), st(1, 1, 16'h1234), "R8");

    // acknowledge
    wr(2, ca(2), ctl(1, 0, 0, 16'h0));
    chk_irq(3'b000, "R5");
    rd(2, sa(2), st(0, 1, 16'h1234), "R5");

    // out-of-range destinations
    wr(0, ca(0), ctl(0, 1, 3, 16'h5555));
    wr(1, ca(1), ctl(0, 1, 16383, 16'h6666));
    chk_irq(3'b000, "R6");
    rd(0, sa(0), '0, "R6");
    rd(0, sa(1), '0, "R6");
    rd(0, sa(2), st(0, 1, 16'h1234), "R6");

    // two senders to one destination
    put(0, 1'b1, ca(1), ctl(0, 1, 0, 16'hAAAA));
    put(2, 1'b1, ca(2), ctl(0, 1, 0, 16'hCCCC));
    step();
    chk_irq(3'b001, "R7");
    rd(1, sa(0), st(1, 1, 16'hAAAA), "R7");

    // ack of core0 racing a send to core0
    put(0, 1'b1, ca(0), ctl(1, 0, 0, 16'h0));
    put(1, 1'b1, ca(1), ctl(0, 1, 0, 16'h7777));
    step();
    chk_irq(3'b001, "R9");
    rd(0, sa(0), st(1, 1, 16'h7777), "R9");
    wr(0, ca(0), ctl(1, 1, 0, 16'h0101));
    chk_irq(3'b001, "R9");
    rd(0, sa(0), st(1, 0, 16'h0101), "R9");
    wr(0, ca(0), ctl(1, 0, 0, 16'h0));
    chk_irq(3'b000, "R5");

    // stray writes
    wr(1, sa(1), 32'hFFFF_FFFF);
    wr(1, 6, ctl(0, 1, 1, 16'h9999));
    wr(1, 7, ctl(0, 1, 1, 16'h9999));
    chk_irq(3'b000, "R10");
    rd(1, sa(1), '0, "R10");
    rd(1, 7, '0, "R10");

    // two ports on one control word
    put(1, 1'b1, ca(0), ctl(0, 1, 2, 16'h1111));
    put(2, 1'b1, ca(0), ctl(0, 1, 1, 16'h2222));
    step();
    chk_irq(3'b100, "R11");
    rd(0, sa(2), st(1, 0, 16'h1111), "R11");
    rd(0, sa(1), '0, "R11");

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule